// File: doc/BRIEF.md
# ALU Flags and Machine Status Register

This block holds the processor's condition state in one byte. It has four arithmetic result flags: carry, zero, negative and overflow. It also has two machine-state bits: interrupt enable and supervisor mode. The arithmetic flags always load together. A source select picks where they load from: the ALU's flag outputs after an arithmetic operation, or the low nibble of the result bus when an earlier snapshot is restored from memory, for example at the end of an interrupt handler. Each machine-state bit loads alone from its own fixed bit of the result bus. To set or clear one, the microcode makes the ALU drive all ones or all zeros and strobes that bit.

One decoded select chooses which of the three load strobes fires in a cycle, so at most one fires. Every bit that is not strobed keeps its value. The combined byte goes without a break to the microcode sequencer for branch decisions. An active-low enable drives the same byte onto the left bus, so the state can be saved. Every load happens on the clock edge that ends the cycle in which the select is presented.

Top module: `flag_status_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all six flags are cleared to 0 on that edge. Reset takes priority over any strobe.
- R2: With `strobe_sel` = 2'b01 and `src_is_bus` = 0, the four arithmetic flags take `alu_flags[3:0]` on the clock edge. The bit order is C, Z, N, V from bit 0 up.
- R3: With `strobe_sel` = 2'b01 and `src_is_bus` = 1, the four arithmetic flags take `zbus[3:0]` in the same order.
- R4: With `strobe_sel` = 2'b10, interrupt enable takes `zbus[4]`. All other flags hold.
- R5: With `strobe_sel` = 2'b11, supervisor mode takes `zbus[5]`. All other flags hold.
- R6: With `strobe_sel` = 2'b00, every flag holds, whatever `zbus`, `alu_flags` and `src_is_bus` carry. A load of the arithmetic group leaves both machine-state bits unchanged.
- R7: `status` is the register contents laid out as bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 interrupt enable, bit 5 supervisor. Bits 7:6 always read 0.
- R8: When `left_oe_n` is 0, `left_en` is 1 and `left_data` equals `status`. When `left_oe_n` is 1, `left_en` is 0 and `left_data` is all zeros. Both outputs follow `left_oe_n` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all loads occur on the rising edge |
| rst_n | input | 1 | Synchronous active-low clear of every flag |
| strobe_sel | input | 2 | Load select: 00 none, 01 arithmetic group, 10 interrupt enable, 11 supervisor |
| src_is_bus | input | 1 | Arithmetic group source: 0 ALU flag outputs, 1 result bus bits 3:0 |
| alu_flags | input | 4 | ALU flag outputs, bit 0 C, 1 Z, 2 N, 3 V |
| zbus | input | 8 | Result bus from the ALU |
| left_oe_n | input | 1 | Active-low request to drive the status byte onto the left bus |
| status | output | 8 | Status byte, always valid, to the microcode sequencer |
| left_data | output | 8 | Status byte for the left bus, zero when not enabled |
| left_en | output | 1 | Left bus drive enable |

## Verification
The assertions take for granted that `alu_flags`, `zbus`, `src_is_bus` and `strobe_sel` are known and steady around each rising edge. They also take for granted that the flags are compared only outside reset. The bench therefore changes every input only on the falling edge and drives all inputs to defined values from time zero. The one-hot nature of the strobes is never assumed, because the two-bit select cannot express two loads at once. A random run therefore covers every select code, including the idle code, next to directed saves and restores and all-ones or all-zeros mode writes.

// File: rtl/stat_reg_pkg.sv
// Package: shared widths, bit positions and the load-select encoding
// for the flag/status register.
package stat_reg_pkg;
    localparam int FLAG_W  = 4;   // arithmetic flags C,Z,N,V
    localparam int N_MODE  = 2;   // interrupt enable, supervisor
    localparam int STAT_W  = 8;   // width of the status byte
    localparam int BUS_W   = 8;   // result bus width
    localparam int BIT_IE  = 4;   // result-bus bit and status bit of interrupt enable
    localparam int PAD_W   = STAT_W - FLAG_W - N_MODE;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'b00,
        SEL_ARITH = 2'b01,
        SEL_IE    = 2'b10,
        SEL_SUP   = 2'b11
    } strobe_sel_e;
endpackage

// File: rtl/arith_flag_bank.sv
// Arithmetic flag bank: four flags loaded as a group when 'load' is high,
// from the ALU flag outputs or from the result bus nibble.
// Assumes: inputs are steady at the rising edge; reset is synchronous, active low.
module arith_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         from_bus,
    input  logic [W-1:0] alu_in,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] q
);
    logic [W-1:0] next_src;

    // Purpose: pick the load source for the group.
    always_comb begin
        next_src = from_bus ? bus_in : alu_in;
    end

    // Purpose: clear on reset, load on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= next_src;
    end

    assert_alu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !from_bus) |=> (q == $past(alu_in)));
    assert_bus_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && from_bus) |=> (q == $past(bus_in)));
    assert_group_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/mode_flag_bit.sv
// Machine-state flag: one flip-flop loaded from a single result-bus bit
// when its own strobe fires. Set or clear is done by the ALU driving all
// ones or all zeros. Assumes: synchronous active-low reset.
module mode_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic din,
    output logic q
);
    // Purpose: clear on reset, capture the bus bit on strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (strobe) q <= din;
    end

    assert_mode_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (q == $past(din)));   // also covers R5 (second instance)
    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(q));
endmodule

// File: rtl/status_left_drv.sv
// Left-bus driver: passes the status byte to the left bus when the
// active-low enable is asserted and returns zeros otherwise.
// Assumes: the bus outside this block merges drivers using left_en.
module status_left_drv #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic [W-1:0] stat_in,
    output logic [W-1:0] drv_data,
    output logic         drv_en
);
    // Purpose: gate the status byte onto the left bus.
    always_comb begin
        drv_en   = !oe_n;
        drv_data = oe_n ? '0 : stat_in;
    end

    assert_left_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (drv_data == '0 && !drv_en));
    assert_left_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (drv_data == stat_in && drv_en));
endmodule

// File: rtl/flag_status_reg.sv
// Flag/status register top: decodes the load select into three strobes,
// holds four arithmetic flags and two machine-state bits, presents the
// byte to the sequencer and, on request, to the left bus.
// Assumes: one select per cycle; all loads on the rising edge.
module flag_status_reg
    import stat_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strobe_sel,
    input  logic              src_is_bus,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic [BUS_W-1:0]  zbus,
    input  logic              left_oe_n,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] left_data,
    output logic              left_en
);
    strobe_sel_e       sel;
    logic [FLAG_W-1:0] arith_q;
    logic [N_MODE-1:0] mode_q;
    logic              arith_ld;

    // Purpose: view the raw select as the enumerated load code.
    always_comb begin
        sel      = strobe_sel_e'(strobe_sel);
        arith_ld = (sel == SEL_ARITH);
    end

    arith_flag_bank #(.W(FLAG_W)) u_arith (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arith_ld),
        .from_bus (src_is_bus),
        .alu_in   (alu_flags),
        .bus_in   (zbus[FLAG_W-1:0]),
        .q        (arith_q)
    );

    // One flip-flop per machine-state bit; bit k uses select code SEL_IE+k
    // and result-bus bit BIT_IE+k.
    for (genvar k = 0; k < N_MODE; k++) begin : g_mode
        logic strobe_k;
        // Purpose: decode this bit's own strobe from the shared select.
        always_comb begin
            strobe_k = (strobe_sel == 2'(int'(SEL_IE) + k));
        end
        mode_flag_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (strobe_k),
            .din    (zbus[BIT_IE + k]),
            .q      (mode_q[k])
        );
    end

    // Purpose: assemble the status byte for the sequencer.
    always_comb begin
        status = {{PAD_W{1'b0}}, mode_q, arith_q};
    end

    status_left_drv #(.W(STAT_W)) u_left (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n     (left_oe_n),
        .stat_in  (status),
        .drv_data (left_data),
        .drv_en   (left_en)
    );

    // Checker state: was reset sampled low at the previous edge?
    logic rst_seen_q;
    // Purpose: remember reset for the clear check below.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // Purpose: R1 clear check after every reset edge.
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_clear_R1: assert (status == '0);
        end
    end

    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_W-1 -: PAD_W] == '0);
    assert_arith_keeps_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_sel == 2'b01) |=> $stable(status[FLAG_W +: N_MODE]));
    assert_mode_keeps_arith_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_sel[1] |=> $stable(status[FLAG_W-1:0]));
endmodule

// File: tb/tb_flag_status_reg.sv
module tb_flag_status_reg;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] strobe_sel;
    logic       src_is_bus;
    logic [3:0] alu_flags;
    logic [7:0] zbus;
    logic       left_oe_n;
    logic [7:0] status;
    logic [7:0] left_data;
    logic       left_en;

    int vectors = 0;
    int fails   = 0;

    // Behavioural model state
    bit m_c, m_z, m_n, m_v, m_ie, m_sup;

    always #4 clk = ~clk;   // 125 MHz

    flag_status_reg dut (
        .clk(clk), .rst_n(rst_n), .strobe_sel(strobe_sel), .src_is_bus(src_is_bus),
        .alu_flags(alu_flags), .zbus(zbus), .left_oe_n(left_oe_n),
        .status(status), .left_data(left_data), .left_en(left_en)
    );

    function automatic logic [7:0] model_byte();
        return {2'b00, m_sup, m_ie, m_v, m_n, m_z, m_c};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, update the model, compare after the edge.
    task automatic apply(input logic rst, input logic [1:0] sel, input logic src,
                         input logic [3:0] af, input logic [7:0] zb, input logic oe_n,
                         input string req);
        @(negedge clk);
        rst_n = rst; strobe_sel = sel; src_is_bus = src;
        alu_flags = af; zbus = zb; left_oe_n = oe_n;
        if (!rst) begin
            {m_c, m_z, m_n, m_v, m_ie, m_sup} = '0;
        end else begin
            case (sel)
                2'b01: {m_v, m_n, m_z, m_c} = src ? zb[3:0] : af;
                2'b10: m_ie  = zb[4];
                2'b11: m_sup = zb[5];
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        check(req, status, model_byte());
        check("R8 data", left_data, oe_n ? 8'h00 : model_byte());
        check("R8 en", {7'b0, left_en}, {7'b0, !oe_n});
    endtask

    initial begin
        rst_n = 1'b0; strobe_sel = 2'b00; src_is_bus = 1'b0;
        alu_flags = 4'h0; zbus = 8'h00; left_oe_n = 1'b1;

        // R1: reset clears, even with a strobe pending
        apply(0, 2'b01, 0, 4'hF, 8'hFF, 1, "R1");
        apply(0, 2'b11, 1, 4'hF, 8'hFF, 0, "R1 priority");

        // R2: load from ALU flag outputs, every pattern, with R7 layout
        for (int i = 0; i < 16; i++)
            apply(1, 2'b01, 0, 4'(i), 8'(~i), 0, "R2/R7");

        // R4/R5: set machine bits with all ones
        apply(1, 2'b10, 0, 4'h0, 8'hFF, 0, "R4 set");
        apply(1, 2'b11, 0, 4'h0, 8'hFF, 0, "R5 set");
        // R6: arithmetic load keeps mode bits
        apply(1, 2'b01, 0, 4'h5, 8'h00, 0, "R6 arith keeps mode");
        // R3: restore from bus
        apply(1, 2'b01, 1, 4'h0, 8'hCA, 0, "R3");
        apply(1, 2'b01, 1, 4'hF, 8'h03, 1, "R3 oe off");
        // R6: idle select holds
        apply(1, 2'b00, 1, 4'hF, 8'hFF, 0, "R6 idle");
        apply(1, 2'b00, 0, 4'h9, 8'h00, 1, "R6 idle");
        // R4/R5: clear with all zeros, other bits hold
        apply(1, 2'b10, 0, 4'hF, 8'h00, 0, "R4 clear");
        apply(1, 2'b11, 1, 4'hF, 8'h00, 0, "R5 clear");
        apply(1, 2'b11, 0, 4'h0, 8'h20, 0, "R5 bit5 only");
        apply(1, 2'b10, 0, 4'h0, 8'h10, 0, "R4 bit4 only");
        // R1 again mid-run
        apply(0, 2'b00, 0, 4'h0, 8'h00, 0, "R1 mid-run");

        // Random mix of all select codes
        for (int i = 0; i < 400; i++)
            apply(($urandom % 23) != 0, 2'($urandom), 1'($urandom), 4'($urandom),
                  8'($urandom), 1'($urandom), "R2-mix");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule